// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds a small bank of 32-bit event counters. Each counter has a type register, and a 10-bit event number in that register chooses what the counter measures. Every cycle the core offers a few event inputs, each made of a valid bit, an event number and an increment amount. A counter adds up the amounts of all inputs whose number matches its type, but only in the following cases:

- the global enable is high;
- the counter's own enable bit is high;
- the current privilege level is not masked by the filter bits of its type register.

A separate software-increment strobe carries a bit mask. It advances, by one, each selected counter whose type holds the software-increment number.

When a counter wraps past bit 31, its sticky overflow status bit is set. Software clears that bit with a write-one-to-clear input. A simple write port loads counter values and type registers. The combining of status bits into an interrupt and the register bus decode belong to the surrounding logic.

Event inputs carry only a valid bit. The bank accepts every event in the cycle it is offered and never applies back-pressure, so there is no ready signal. The control inputs are plain levels, sampled at each rising clock edge.

Top module: `perf_event_bank`

## Requirements
- R1: After reset every counter value, every type register and every overflow status bit reads zero.
- R2: A type write stores only the bits under mask 0xF800_03FF, and all other bits read zero. A counter write loads all 32 bits. A counter write wins over counting in the same cycle, so that cycle's increments are dropped.
- R3: No counter changes unless `glb_en` is 1. Counter i only counts while `ctr_en[i]` is 1.
- R4: Event input k adds its amount to counter i when it is valid and its event number equals type bits [9:0]. An event input that carries event number 0x000 never counts. Event numbers 0x008 (instructions) and 0x011 (cycles) are the hardware events.
- R5: When several event inputs match the same counter in one cycle, their amounts are summed into a single update.
- R6: The privilege filter works as follows:
  - at level 2, a counter counts only if type bit 27 is 1;
  - at level 1, type bit 31 set blocks counting;
  - at level 0, type bit 30 set blocks counting;
  - level 3 always passes.
- R7: The overflow status bit i becomes 1 when counter i has bit 31 equal to 1 before an update and 0 after it. The bit is sticky.
- R8: A software-increment strobe adds exactly 1 to each counter i that meets all of the following: its mask bit i is set, it is enabled, it passes the filter, and its type number is 0x000. The overflow rule of R7 applies.
- R9: `ovf_clr[i]` clears overflow bit i. If an overflow of counter i occurs in the same cycle, the set wins.
- R10: All results show on the outputs one clock after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global count enable |
| ctr_en | input | NUM_CTR | Per-counter enable bits |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| ev_valid | input | NUM_EV | Event input valid bits |
| ev_code | input | NUM_EV*10 | Event numbers, input k at bits [10k+9:10k] |
| ev_amount | input | NUM_EV*INC_W | Increment amounts, input k at [INC_W*k +: INC_W] |
| swinc_valid | input | 1 | Software-increment strobe |
| swinc_mask | input | NUM_CTR | Counters selected for software increment |
| wr_en | input | 1 | Write-port strobe |
| wr_is_type | input | 1 | 1 writes a type register, 0 writes a counter |
| wr_idx | input | IDX_W | Counter index of the write |
| wr_data | input | 32 | Write data |
| ovf_clr | input | NUM_CTR | Write-one-to-clear for overflow bits |
| ctr_val | output | NUM_CTR*32 | Counter values, counter i at [32i +: 32] |
| ctr_type | output | NUM_CTR*32 | Type registers, counter i at [32i +: 32] |
| ovf_status | output | NUM_CTR | Sticky overflow bits |

## Verification
A write-port load of a counter can land in the same cycle as matching events or a software increment aimed at that counter. The bench provokes this by presetting a counter near the wrap point and then loading it while events are still valid. It is judged correct when the counter holds exactly the loaded data and its overflow bit does not change. The second collision is an overflow and a clear of the same status bit in one cycle. The bench pushes a counter across bit 31 while pulsing `ovf_clr` for it, and expects the bit to read 1 afterwards. Every cycle, all counters, type registers and status bits are compared against an arithmetic model built from the requirements. The privilege filter is swept over all four levels and all eight filter-bit patterns, and the software-increment mask over all sixteen values.

// File: rtl/perf_bank_pkg.sv
package perf_bank_pkg;
  localparam int CTR_W  = 32;
  localparam int CODE_W = 10;

  localparam logic [CODE_W-1:0] EVC_SWINC = 10'h000;
  localparam logic [CODE_W-1:0] EVC_INSTR = 10'h008;
  localparam logic [CODE_W-1:0] EVC_CYCLE = 10'h011;

  localparam logic [CTR_W-1:0] TYPE_KEEP = 32'hF800_03FF;

  localparam int FLT_HYP_BIT  = 27;
  localparam int FLT_KERN_BIT = 31;
  localparam int FLT_USER_BIT = 30;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_KERN = 2'd1,
    LVL_HYP  = 2'd2,
    LVL_TOP  = 2'd3
  } priv_e;

  // Privilege filter decision for one type register
  function automatic logic priv_pass(input logic [1:0] lvl, input logic [CTR_W-1:0] typ);
    case (priv_e'(lvl))
      LVL_HYP:  return typ[FLT_HYP_BIT];
      LVL_KERN: return !typ[FLT_KERN_BIT];
      LVL_USER: return !typ[FLT_USER_BIT];
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pcb_inc_sum.sv
module pcb_inc_sum
  import perf_bank_pkg::*;
#(
  parameter int NUM_EV = 2,
  parameter int INC_W  = 8,
  parameter int SUM_W  = INC_W + $clog2(NUM_EV + 1) + 1
) (
  input  logic [NUM_EV-1:0]        ev_valid,
  input  logic [NUM_EV*CODE_W-1:0] ev_code,
  input  logic [NUM_EV*INC_W-1:0]  ev_amount,
  input  logic [CODE_W-1:0]        type_code,
  input  logic                     swinc_hit,
  output logic [SUM_W-1:0]         inc
);
  logic swinc_typed;
  assign swinc_typed = (type_code == EVC_SWINC);

  always_comb begin
    inc = '0;
    for (int k = 0; k < NUM_EV; k++) begin
      if (ev_valid[k] && ev_code[k*CODE_W +: CODE_W] == type_code && !swinc_typed)
        inc = inc + SUM_W'(ev_amount[k*INC_W +: INC_W]);
    end
    if (swinc_hit && swinc_typed)
      inc = inc + SUM_W'(1);
  end
endmodule

// File: rtl/pcb_counter_slice.sv
module pcb_counter_slice
  import perf_bank_pkg::*;
#(
  parameter int SUM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic             own_en,
  input  logic [1:0]       priv_lvl,
  input  logic [SUM_W-1:0] inc,
  input  logic             ld_cnt,
  input  logic             ld_type,
  input  logic [CTR_W-1:0] wr_data,
  output logic [CTR_W-1:0] ctr_q,
  output logic [CTR_W-1:0] type_q,
  output logic             ovf_set
);
  logic             cnt_ok;
  logic [CTR_W-1:0] ctr_next;

  assign cnt_ok   = glb_en && own_en && priv_pass(priv_lvl, type_q);
  assign ctr_next = ctr_q + CTR_W'(inc);
  assign ovf_set  = cnt_ok && !ld_cnt && ctr_q[CTR_W-1] && !ctr_next[CTR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr_q  <= '0;
      type_q <= '0;
    end else begin
      if (ld_cnt)
        ctr_q <= wr_data;
      else if (cnt_ok)
        ctr_q <= ctr_next;
      if (ld_type)
        type_q <= wr_data & TYPE_KEEP;
    end
  end
endmodule

// File: rtl/perf_event_bank.sv
module perf_event_bank
  import perf_bank_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int NUM_EV  = 2,
  parameter int INC_W   = 8,
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int SUM_W  = INC_W + $clog2(NUM_EV + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     glb_en,
  input  logic [NUM_CTR-1:0]       ctr_en,
  input  logic [1:0]               priv_lvl,
  input  logic [NUM_EV-1:0]        ev_valid,
  input  logic [NUM_EV*CODE_W-1:0] ev_code,
  input  logic [NUM_EV*INC_W-1:0]  ev_amount,
  input  logic                     swinc_valid,
  input  logic [NUM_CTR-1:0]       swinc_mask,
  input  logic                     wr_en,
  input  logic                     wr_is_type,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [CTR_W-1:0]         wr_data,
  input  logic [NUM_CTR-1:0]       ovf_clr,
  output logic [NUM_CTR*CTR_W-1:0] ctr_val,
  output logic [NUM_CTR*CTR_W-1:0] ctr_type,
  output logic [NUM_CTR-1:0]       ovf_status
);
  logic [NUM_CTR-1:0] ovf_set;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [SUM_W-1:0] inc;
    logic [CTR_W-1:0] type_q;
    logic             hit_wr;

    assign hit_wr = wr_en && (wr_idx == IDX_W'(i));
    assign ctr_type[i*CTR_W +: CTR_W] = type_q;

    pcb_inc_sum #(.NUM_EV(NUM_EV), .INC_W(INC_W), .SUM_W(SUM_W)) u_sum (
      .ev_valid  (ev_valid),
      .ev_code   (ev_code),
      .ev_amount (ev_amount),
      .type_code (type_q[CODE_W-1:0]),
      .swinc_hit (swinc_valid && swinc_mask[i]),
      .inc       (inc)
    );

    pcb_counter_slice #(.SUM_W(SUM_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .glb_en   (glb_en),
      .own_en   (ctr_en[i]),
      .priv_lvl (priv_lvl),
      .inc      (inc),
      .ld_cnt   (hit_wr && !wr_is_type),
      .ld_type  (hit_wr && wr_is_type),
      .wr_data  (wr_data),
      .ctr_q    (ctr_val[i*CTR_W +: CTR_W]),
      .type_q   (type_q),
      .ovf_set  (ovf_set[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_status <= '0;
    else        ovf_status <= (ovf_status & ~ovf_clr) | ovf_set;
  end
endmodule

// File: rtl/perf_event_bank_chk.sv
module perf_event_bank_chk #(
  parameter int NUM_CTR = 4,
  parameter int IDX_W   = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   glb_en,
  input logic                   wr_en,
  input logic                   wr_is_type,
  input logic [IDX_W-1:0]       wr_idx,
  input logic [31:0]            wr_data,
  input logic [NUM_CTR-1:0]     ovf_clr,
  input logic [NUM_CTR*32-1:0]  ctr_val,
  input logic [NUM_CTR*32-1:0]  ctr_type,
  input logic [NUM_CTR-1:0]     ovf_status
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !wr_en) |=> $stable(ctr_val)); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_status & $past(ovf_status & ~ovf_clr)) == $past(ovf_status & ~ovf_clr))); // R9

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    AST_TYPE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_type[i*32 +: 32] & 32'h07FF_FC00) == 32'h0); // R2

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_is_type && wr_idx == IDX_W'(i)) |=> (ctr_val[i*32 +: 32] == $past(wr_data))); // R2

    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_val[i*32 + 31] && !wr_en) |=> (ctr_val[i*32 + 31] || ovf_status[i])); // R7
  end
endmodule

bind perf_event_bank perf_event_bank_chk #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .glb_en     (glb_en),
  .wr_en      (wr_en),
  .wr_is_type (wr_is_type),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .ovf_clr    (ovf_clr),
  .ctr_val    (ctr_val),
  .ctr_type   (ctr_type),
  .ovf_status (ovf_status)
);

// File: tb/perf_event_bank_tb_top.sv
module perf_event_bank_tb_top;
  localparam int NC = 4;
  localparam int NE = 2;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          glb_en;
  logic [NC-1:0] ctr_en;
  logic [1:0]    priv_lvl;
  logic [NE-1:0] ev_valid;
  logic [NE*10-1:0] ev_code;
  logic [NE*IW-1:0] ev_amount;
  logic          swinc_valid;
  logic [NC-1:0] swinc_mask;
  logic          wr_en, wr_is_type;
  logic [1:0]    wr_idx;
  logic [31:0]   wr_data;
  logic [NC-1:0] ovf_clr;
  logic [NC*32-1:0] ctr_val, ctr_type;
  logic [NC-1:0] ovf_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0]   m_ctr [NC];
  logic [31:0]   m_typ [NC];
  logic [NC-1:0] m_ovf;

  always #5 clk = ~clk;

  perf_event_bank #(.NUM_CTR(NC), .NUM_EV(NE), .INC_W(IW)) dut_i (.*);

  function automatic bit pass_f(input logic [1:0] l, input logic [31:0] t);
    if (l == 2'd2) return t[27];
    if (l == 2'd1) return !t[31];
    if (l == 2'd0) return !t[30];
    return 1'b1;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ev_valid = '0; ev_code = '0; ev_amount = '0;
    swinc_valid = 0; swinc_mask = '0;
    wr_en = 0; wr_is_type = 0; wr_idx = '0; wr_data = '0; ovf_clr = '0;
  endtask

  task automatic model_step();
    logic [NC-1:0] set;
    set = '0;
    for (int i = 0; i < NC; i++) begin
      logic [31:0] inc, n;
      logic hit;
      hit = wr_en && (wr_idx == 2'(i));
      inc = 0;
      for (int k = 0; k < NE; k++)
        if (ev_valid[k] && ev_code[k*10 +: 10] != 10'h0 && ev_code[k*10 +: 10] == m_typ[i][9:0])
          inc += 32'(ev_amount[k*IW +: IW]);
      if (swinc_valid && swinc_mask[i] && m_typ[i][9:0] == 10'h0) inc += 1;
      if (hit && !wr_is_type) m_ctr[i] = wr_data;
      else if (glb_en && ctr_en[i] && pass_f(priv_lvl, m_typ[i])) begin
        n = m_ctr[i] + inc;
        if (m_ctr[i][31] && !n[31]) set[i] = 1'b1;
        m_ctr[i] = n;
      end
      if (hit && wr_is_type) m_typ[i] = wr_data & 32'hF800_03FF;
    end
    m_ovf = (m_ovf & ~ovf_clr) | set;
  endtask

  task automatic compare_all(input string tag);
    for (int i = 0; i < NC; i++) begin
      chk(ctr_val[i*32 +: 32], m_ctr[i], tag);
      chk(ctr_type[i*32 +: 32], m_typ[i], tag);
    end
    chk(32'(ovf_status), 32'(m_ovf), tag);
  endtask

  // One cycle: model follows current inputs, outputs checked one clock later (R10)
  task automatic tick(input string tag);
    model_step();
    @(posedge clk); #2;
    compare_all(tag);
    idle();
  endtask

  task automatic wr(input bit typ, input int idx, input logic [31:0] d, input string tag);
    wr_en = 1; wr_is_type = typ; wr_idx = 2'(idx); wr_data = d;
    tick(tag);
  endtask

  task automatic ev(input int k, input logic [9:0] c, input logic [7:0] a);
    ev_valid[k] = 1; ev_code[k*10 +: 10] = c; ev_amount[k*IW +: IW] = a;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0; glb_en = 0; ctr_en = '0; priv_lvl = 2'd0;
    for (int i = 0; i < NC; i++) begin m_ctr[i] = 0; m_typ[i] = 0; end
    m_ovf = '0;
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    compare_all("R1 reset");

    // R2 masking of type write, full counter load
    wr(1, 0, 32'hFFFF_FFFF, "R2 type mask");
    wr(0, 3, 32'hDEAD_BEEF, "R2 counter load");

    // setup types
    wr(1, 0, 32'h0000_0008, "R2 setup");
    wr(1, 1, 32'h0000_0011, "R2 setup");
    wr(1, 2, 32'h0000_0000, "R2 setup");
    wr(1, 3, 32'h4000_0008, "R2 setup");
    wr(0, 3, 32'h0, "R2 setup");

    // R3 global enable off: nothing moves
    ctr_en = '1; glb_en = 0;
    ev(0, 10'h008, 8'd5); ev(1, 10'h011, 8'd7);
    tick("R3 global off");
    glb_en = 1; ctr_en = 4'b0010;
    ev(0, 10'h008, 8'd5); ev(1, 10'h011, 8'd7);
    tick("R3 per-counter enable");
    ctr_en = '1;

    // R4 matching, user level filter on counter 3
    ev(0, 10'h008, 8'd5); ev(1, 10'h011, 8'd7);
    tick("R4 match");
    ev(0, 10'h000, 8'd9); ev(1, 10'h123, 8'd4);
    tick("R4 code 0 and foreign code ignored");

    // R5 summing
    ev(0, 10'h008, 8'd200); ev(1, 10'h008, 8'd55);
    tick("R5 sum");
    ev(0, 10'h011, 8'd255); ev(1, 10'h011, 8'd255);
    tick("R5 sum max");

    // R6 privilege sweep: all levels and all filter-bit patterns
    for (int l = 0; l < 4; l++) begin
      for (int b = 0; b < 8; b++) begin
        logic [31:0] t;
        t = 32'h8 | (b[0] ? 32'h0800_0000 : 0) | (b[1] ? 32'h4000_0000 : 0) | (b[2] ? 32'h8000_0000 : 0);
        wr(1, 0, t, "R6 filter setup");
        priv_lvl = 2'(l);
        ev(0, 10'h008, 8'd2); ev(1, 10'h008, 8'd1);
        tick("R6 filter");
      end
    end
    priv_lvl = 2'd0;
    wr(1, 0, 32'h8, "R6 restore");

    // R7 overflow
    wr(0, 1, 32'h7FFF_FFFF, "R7 preset");
    ev(1, 10'h011, 8'd1);
    tick("R7 no flag at 0x80000000");
    wr(0, 1, 32'hFFFF_FFFE, "R7 preset");
    ev(1, 10'h011, 8'd5);
    tick("R7 wrap sets flag");
    // R2 load beats count in same cycle
    wr_en = 1; wr_is_type = 0; wr_idx = 2'd0; wr_data = 32'hFFFF_FFFF;
    ev(0, 10'h008, 8'd9);
    tick("R2 load wins over count");

    // R8 software increment sweep
    for (int m = 0; m < 16; m++) begin
      swinc_valid = 1; swinc_mask = 4'(m);
      tick("R8 swinc mask");
    end
    wr(0, 2, 32'hFFFF_FFFF, "R8 preset");
    swinc_valid = 1; swinc_mask = 4'b0100;
    tick("R8 swinc overflow");
    ctr_en = 4'b1011; swinc_valid = 1; swinc_mask = 4'b1111;
    tick("R8 swinc disabled counter");
    ctr_en = '1;

    // R9 clear, and set beats clear
    ovf_clr = 4'b0100;
    tick("R9 clear");
    wr(0, 0, 32'hFFFF_FFFF, "R9 preset");
    ev(0, 10'h008, 8'd1); ovf_clr = 4'b0001;
    tick("R9 set wins");
    ev(0, 10'h008, 8'd1); ovf_clr = 4'b0010;
    tick("R9 clear while counting");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule